// File: doc/BRIEF.md
# Off-core request event filter counter

This block counts off-core transactions that pass a programmable filter. A request strobe issues a transaction with a tag and a 4-bit request class. A later response strobe with the same tag carries a 2-bit snoop class. A small table indexed by tag keeps each in-flight request's class until its response arrives. The filter register holds a request-class mask and a snoop-response mask. In the normal mode, a transaction counts once, on its response, when both masks accept it.

A mode bit switches the counter to occupancy accumulation. On every clock the counter adds how many in-flight requests have a class the request mask accepts. The result is a weighted count of cycles with requests outstanding. This mode needs the response field to be empty, and only instances built with `HAS_OCC = 1` have the mode bit. Software reaches both registers through one write port and one combinational read port: select 0 is the filter and select 1 is the 48-bit counter.

Top module: `offcore_evt_counter`

## Requirements
- R1: After reset the filter reads 0 and the counter reads 0.
- R2: Filter bits 15:0 (except bit 6), bits 33, 34, 36 and 37, and bit 38 (only when `HAS_OCC = 1`) hold what is written. Every other bit reads 0.
- R3: A write with `wr_sel = 1` clears the counter at that edge and takes priority over any increment in the same cycle.
- R4: Normal mode (bit 38 = 0): a response adds 1 to the counter at its edge when two conditions hold. First, filter bit c or filter bit 15 is set, where c is the class of the in-flight request. Second, the filter bit selected by `rsp_snp` is set, with code 0 selecting bit 33, 1 selecting bit 34, 2 selecting bit 36 and 3 selecting bit 37. Several bits may be set in either mask.
- R5: If the request mask (bits 15:0) is empty, or all four response bits are clear, the counter never increments in normal mode.
- R6: A response whose tag has no request in flight is ignored.
- R7: Occupancy mode (bit 38 = 1 and bits 37:16 all zero): at every edge the counter adds the number of in-flight requests whose class matches bits 15:0. A request accepted at edge e and answered at edge f contributes f - e.
- R8: A request and a response with the same tag in the same cycle form a zero-length transaction. It adds 0 in occupancy mode. In normal mode it counts once if its `req_cls` and `rsp_snp` match.
- R9: If bit 38 is set while any of bits 37:16 is set, the counter holds its value.
- R10: When `HAS_OCC = 0`, bit 38 ignores writes and reads 0, so the counter always works in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 filter, 1 counter (clear) |
| wr_data | input | 64 | Write data |
| rd_sel | input | 1 | Read target: 0 filter, 1 counter |
| rd_data | output | 64 | Read data (combinational) |
| req_valid | input | 1 | Request issue strobe |
| req_tag | input | TAG_W | Request tag |
| req_cls | input | 4 | Request class (index into filter bits 15:0) |
| rsp_valid | input | 1 | Response strobe |
| rsp_tag | input | TAG_W | Response tag |
| rsp_snp | input | 2 | Snoop class code |
| count | output | CNT_W | Counter value |

## Verification
The assertions check several properties on every clock. Reserved filter bits read zero. A counter write clears the count. The normal-mode count never rises by more than one per cycle and never moves without a response. The count holds when either mask is empty and when occupancy mode is selected with a response bit set. Only the bench scenarios can show the exact totals: each class and snoop pairing in the sweep, the f - e weighting of overlapping in-flight requests, zero-length transactions, and a response with an unknown tag leaving the count alone.

// File: rtl/offcore_evt_counter.sv
module offcore_evt_counter #(
  parameter int TAG_W   = 4,
  parameter int CNT_W   = 48,
  parameter bit HAS_OCC = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [63:0]      wr_data,
  input  logic             rd_sel,
  output logic [63:0]      rd_data,
  input  logic             req_valid,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [3:0]       req_cls,
  input  logic             rsp_valid,
  input  logic [TAG_W-1:0] rsp_tag,
  input  logic [1:0]       rsp_snp,
  output logic [CNT_W-1:0] count
);
  localparam int DEPTH = 1 << TAG_W;
  localparam logic [63:0] OCC_BIT = 64'h0000_0040_0000_0000;
  localparam logic [63:0] WMASK   = 64'h0000_0036_0000_FFBF | (HAS_OCC ? OCC_BIT : 64'h0);

  logic [63:0]      filt;
  logic [CNT_W-1:0] cnt;
  logic [DEPTH-1:0] vld;
  logic [3:0]       cls_q [DEPTH];
  logic [TAG_W:0]   occ_sum;

  function automatic logic req_hit(input logic [15:0] m, input logic [3:0] c);
    return m[c] | m[15];
  endfunction

  wire [3:0] rmask    = {filt[37], filt[36], filt[34], filt[33]};
  wire       occ_mode = filt[38];
  wire       occ_ok   = occ_mode && (filt[37:16] == '0);
  wire       zero_len = req_valid && rsp_valid && (req_tag == rsp_tag);
  wire [3:0] ev_cls   = zero_len ? req_cls : cls_q[rsp_tag];
  wire       ev_live  = zero_len || vld[rsp_tag];
  wire       norm_inc = !occ_mode && rsp_valid && ev_live &&
                        req_hit(filt[15:0], ev_cls) && rmask[rsp_snp];

  always_comb begin
    occ_sum = '0;
    for (int i = 0; i < DEPTH; i++)
      if (vld[i] && req_hit(filt[15:0], cls_q[i])) occ_sum = occ_sum + (TAG_W+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) cls_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (rsp_valid && rsp_tag == TAG_W'(i)) vld[i] <= 1'b0;
        if (req_valid && req_tag == TAG_W'(i) && !zero_len) begin
          vld[i]   <= 1'b1;
          cls_q[i] <= req_cls;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt <= '0;
      cnt  <= '0;
    end else begin
      if (wr_en && !wr_sel) filt <= wr_data & WMASK;
      if (wr_en && wr_sel)  cnt  <= '0;
      else if (occ_ok)      cnt  <= cnt + CNT_W'(occ_sum);
      else if (norm_inc)    cnt  <= cnt + CNT_W'(1);
    end
  end

  assign rd_data = rd_sel ? {{(64-CNT_W){1'b0}}, cnt} : filt;
  assign count   = cnt;
endmodule

module offcore_evt_counter_chk #(
  parameter int CNT_W   = 48,
  parameter bit HAS_OCC = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_sel,
  input logic             rd_sel,
  input logic [63:0]      rd_data,
  input logic             rsp_valid,
  input logic [63:0]      filt,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [63:0] KEEP = 64'h0000_0076_0000_FFBF;

  assert_filter_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel |-> ((rd_data & ~KEEP) == 64'h0));

  assert_no_occ_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_OCC |-> !filt[38]);

  assert_count_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel) |=> (cnt == '0));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !filt[38]) |=> ((cnt - $past(cnt)) <= CNT_W'(1)));

  assert_hold_without_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !filt[38] && !rsp_valid) |=> $stable(cnt));

  assert_empty_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !filt[38] && (filt[15:0] == '0 || {filt[37:36], filt[34:33]} == '0))
      |=> $stable(cnt));

  assert_occ_invalid_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && filt[38] && filt[37:16] != '0) |=> $stable(cnt));
endmodule

bind offcore_evt_counter offcore_evt_counter_chk #(.CNT_W(CNT_W), .HAS_OCC(HAS_OCC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .rd_sel(rd_sel),
  .rd_data(rd_data), .rsp_valid(rsp_valid), .filt(filt), .cnt(cnt)
);

// File: tb/offcore_evt_counter_bench.sv
`timescale 1ns/1ps
module offcore_evt_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [63:0] wr_data = '0;
  logic        req_valid = 1'b0, rsp_valid = 1'b0;
  logic [3:0]  req_tag = '0, rsp_tag = '0, req_cls = '0;
  logic [1:0]  rsp_snp = '0;
  logic [63:0] rd_data, rd_data_n1;
  logic [47:0] count, count_n1;
  int n_chk = 0, n_bad = 0;

  localparam logic [63:0] WM = 64'h0000_0076_0000_FFBF;
  localparam logic [63:0] B38 = 64'h1 << 38;

  always #5 clk = ~clk;

  offcore_evt_counter u_offcore_evt_counter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .req_valid(req_valid), .req_tag(req_tag),
    .req_cls(req_cls), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_snp(rsp_snp),
    .count(count));

  offcore_evt_counter #(.HAS_OCC(1'b0)) u_offcore_evt_counter_n1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data_n1), .req_valid(req_valid), .req_tag(req_tag),
    .req_cls(req_cls), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_snp(rsp_snp),
    .count(count_n1));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int rbit(input int r);
    return (r == 0) ? 33 : (r == 1) ? 34 : (r == 2) ? 36 : 37;
  endfunction

  task automatic wr(input logic sel, input logic [63:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [63:0] v);
    rd_sel = sel; #1 v = rd_data;
  endtask

  task automatic txn(input logic [3:0] tag, input logic [3:0] c, input logic [1:0] s);
    @(negedge clk); req_valid = 1'b1; req_tag = tag; req_cls = c;
    @(negedge clk); req_valid = 1'b0; rsp_valid = 1'b1; rsp_tag = tag; rsp_snp = s;
    @(negedge clk); rsp_valid = 1'b0;
  endtask

  task automatic occ_run();
    for (int k = 0; k < 26; k++) begin
      @(negedge clk);
      req_valid = (k < 8); req_tag = 4'(k); req_cls = 4'(k);
      rsp_valid = 1'b0;
      for (int t = 0; t < 8; t++)
        if (3*t + 1 == k) begin rsp_valid = 1'b1; rsp_tag = 4'(t); rsp_snp = 2'd0; end
    end
    @(negedge clk); req_valid = 1'b0; rsp_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(1'b0, v); chk("R1 filter", v, 64'h0);
    rd(1'b1, v); chk("R1 counter", v, 64'h0);

    wr(1'b0, '1);
    rd(1'b0, v); chk("R2 readback", v, WM);
    chk("R10 readback", rd_data_n1, WM & ~B38);

    for (int b = 0; b < 16; b++)
      for (int r = 0; r < 4; r++) begin
        wr(1'b0, (64'h1 << b) | (64'h1 << rbit(r)));
        wr(1'b1, '0);
        for (int c = 0; c < 16; c++)
          for (int s = 0; s < 4; s++) txn(4'(c), 4'(c), 2'(s));
        rd(1'b1, v);
        if (b == 6) chk("R5 reserved req bit", v, 64'h0);
        else chk("R4 sweep", v, (b == 15) ? 64'd16 : 64'd1);
      end

    wr(1'b0, 64'h0000_0000_0000_FFBF); wr(1'b1, '0);
    for (int s = 0; s < 4; s++) txn(4'd2, 4'd5, 2'(s));
    rd(1'b1, v); chk("R5 empty rsp mask", v, 64'h0);

    wr(1'b0, 64'h9 | (64'h1 << 33) | (64'h1 << 37)); wr(1'b1, '0);
    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 4; s++) txn(4'(c), 4'(c), 2'(s));
    rd(1'b1, v); chk("R4 multi-bit", v, 64'd4);

    wr(1'b0, 64'h8000 | (64'hF << 33)); wr(1'b1, '0);
    @(negedge clk); rsp_valid = 1'b1; rsp_tag = 4'd9; rsp_snp = 2'd0;
    @(negedge clk); rsp_valid = 1'b0;
    rd(1'b1, v); chk("R6 orphan rsp", v, 64'h0);

    txn(4'd1, 4'd1, 2'd0);
    @(negedge clk); req_valid = 1'b1; req_tag = 4'd4; req_cls = 4'd0;
    @(negedge clk); req_valid = 1'b0; rsp_valid = 1'b1; rsp_tag = 4'd4;
    wr_en = 1'b1; wr_sel = 1'b1;
    @(negedge clk); rsp_valid = 1'b0; wr_en = 1'b0;
    rd(1'b1, v); chk("R3 clear wins", v, 64'h0);
    txn(4'd4, 4'd0, 2'd1);
    rd(1'b1, v); chk("R3 after clear", v, 64'd1);

    wr(1'b0, B38 | 64'h25); wr(1'b1, '0);
    occ_run();
    rd(1'b1, v); chk("R7 classes 0,2,5", v, 64'd17);

    wr(1'b0, B38 | 64'h8000); wr(1'b1, '0);
    occ_run();
    rd(1'b1, v); chk("R7 any class", v, 64'd64);

    wr(1'b0, B38 | 64'h1 | (64'h1 << 33)); wr(1'b1, '0);
    occ_run();
    rd(1'b1, v); chk("R9 invalid occ", v, 64'h0);

    wr(1'b0, B38 | 64'h8000); wr(1'b1, '0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); req_valid = 1'b1; rsp_valid = 1'b1;
      req_tag = 4'd3; rsp_tag = 4'd3; req_cls = 4'd7; rsp_snp = 2'd0;
    end
    @(negedge clk); req_valid = 1'b0; rsp_valid = 1'b0;
    rd(1'b1, v); chk("R8 zero-length occ", v, 64'h0);

    wr(1'b0, 64'h8000 | (64'h1 << 33)); wr(1'b1, '0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); req_valid = 1'b1; rsp_valid = 1'b1;
      req_tag = 4'd3; rsp_tag = 4'd3; req_cls = 4'd7; rsp_snp = 2'd0;
    end
    @(negedge clk); req_valid = 1'b0; rsp_valid = 1'b0;
    rd(1'b1, v); chk("R8 zero-length normal", v, 64'd5);

    wr(1'b0, B38 | 64'h8000 | (64'h1 << 33)); wr(1'b1, '0);
    txn(4'd6, 4'd2, 2'd0);
    rd_sel = 1'b1; #1 chk("R10 normal on n1", rd_data_n1, 64'd1);
    chk("R9 occ held on main", count, 48'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule